// File: doc/BRIEF.md
# Key-Sequence Watchdog Timer

This block is a software-serviced watchdog. It sits idle after reset until software arms it through a small register write port. Once armed, it counts down from a programmable start value, advancing one step on each cycle where the `tick` strobe is high. To keep the system alive, software must write two fixed 16-bit keys to the key register, one after the other. A matching pair puts the start value back into the counter.

If the count runs out, the block raises a one-cycle reset request toward the system reset controller. It also sets a sticky flag that records the expiry. Arming cannot be undone by software. Only the block's reset input returns it to the idle state.

The write port selects one of three targets: the control word, the start value, or the key. The current count, the armed flag, the expiry flag and the key-tracker state are all visible on output pins.

Top module: `kwd_watchdog`

## Requirements
- R1: After `rst_n` is low, `enabled`, `expired`, `rst_req`, `key_half` are 0, `count` is 0, and the stored start value is all ones.
- R2: While not armed, `tick` and key writes do not change `count` (stays 0), `key_half` stays 0 and `rst_req` stays 0.
- R3: A write with `wr_sel`=0 and `wr_data[0]`=1 to a disarmed block sets `enabled` and loads `count` with the stored start value one cycle later; a write with `wr_sel`=1 stores `wr_data` as the start value.
- R4: While armed and not expired, a cycle with `tick` high, no completed key pair and `count` above 1 lowers `count` by exactly 1.
- R5: A key write (`wr_sel`=2) of 0xE51A followed by a separate later key write of 0xA35C reloads `count` with the stored start value on the edge that takes the second write; after 0xE51A, `key_half` reads 1.
- R6: A key write of 0xA35C while `key_half` is 0 leaves `count` on its normal path and does not reload it.
- R7: After 0xE51A, a key write of any value other than 0xA35C (0xE51A included) clears `key_half` without a reload, so a following 0xA35C does nothing.
- R8: A completed pair services once only; a further 0xA35C without a new 0xE51A does not reload.
- R9: A cycle that is armed, not expired, with `tick` high, no completed pair and `count` at 0 or 1 makes `count` 0, `expired` 1 and `rst_req` 1 at the next edge; `rst_req` falls after one cycle.
- R10: `expired` stays set until `rst_n`; after expiry `count` stays 0, key writes are ignored and `rst_req` does not pulse again.
- R11: A control write with `wr_data[0]`=0 never clears `enabled`.
- R12: When a completed pair and the final tick fall in the same cycle, the reload wins and no expiry occurs.
- R13: Writing a new start value while armed leaves `count` unchanged; the new value is used at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count-step strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 start value, 2 key, 3 none |
| wr_data | input | 16 | Write data |
| rst_req | output | 1 | One-cycle system reset request |
| expired | output | 1 | Sticky expiry flag |
| enabled | output | 1 | Armed flag |
| count | output | CNT_W | Current down-count |
| key_half | output | 1 | First key accepted, waiting for second |

## Verification
The assertions assume that `wr_sel` and `wr_data` are stable and known whenever `wr_en` is high. They also assume that `tick` is a plain level sampled at each edge, with no relation to the write port. The bench drives every input only on the falling edge and always from defined values, so these assumptions hold. The random stimulus mixes correct keys, stray keys, start-value writes and disarm attempts with random ticks. Start values are kept small, so that both expiries and long serviced runs occur within each reset window.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam int KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY_FIRST  = 16'hE51A;
  localparam logic [KEY_W-1:0] KEY_SECOND = 16'hA35C;

  typedef enum logic [1:0] {
    SEL_CTRL    = 2'd0,
    SEL_PRELOAD = 2'd1,
    SEL_KEY     = 2'd2,
    SEL_NONE    = 2'd3
  } wsel_e;

  typedef enum logic {
    KS_IDLE = 1'b0,
    KS_HALF = 1'b1
  } kstate_e;

  typedef struct packed {
    kstate_e nxt;
    logic    service;
  } kstep_t;

  // One key write through the two-step handshake.
  function automatic kstep_t key_step(kstate_e cur, logic [KEY_W-1:0] key);
    kstep_t r;
    r.nxt     = KS_IDLE;
    r.service = 1'b0;
    if (cur == KS_IDLE) begin
      if (key == KEY_FIRST) r.nxt = KS_HALF;
    end else if (key == KEY_SECOND) begin
      r.service = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/kwd_ctrl_regs.sv
module kwd_ctrl_regs
  import kwd_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] PRELOAD_INIT = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [KEY_W-1:0] wr_data,
  output logic             enabled,
  output logic [CNT_W-1:0] preload,
  output logic             arm
);
  logic ctrl_wr, pre_wr;

  assign ctrl_wr = wr_en && (wsel_e'(wr_sel) == SEL_CTRL);
  assign pre_wr  = wr_en && (wsel_e'(wr_sel) == SEL_PRELOAD);
  assign arm     = ctrl_wr && wr_data[0] && !enabled;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enabled <= 1'b0;
      preload <= PRELOAD_INIT;
    end else begin
      if (arm) enabled <= 1'b1;
      if (pre_wr) preload <= CNT_W'(wr_data);
    end
  end

  p_enable_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    enabled |=> enabled);
  p_arm_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> enabled);
endmodule

// File: rtl/kwd_key_tracker.sv
module kwd_key_tracker
  import kwd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_wr,
  input  logic [KEY_W-1:0] key,
  output logic             key_half,
  output logic             service
);
  kstate_e st;
  kstep_t  stp;

  assign stp      = key_step(st, key);
  assign service  = key_wr && stp.service;
  assign key_half = (st == KS_HALF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= KS_IDLE;
    else if (key_wr) st <= stp.nxt;
  end

  p_first_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && !key_half && key == KEY_FIRST) |=> key_half);
  p_wrong_key_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (key_wr && key_half && key != KEY_SECOND) |=> !key_half);
  p_pair_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    service |=> !key_half);
endmodule

// File: rtl/kwd_down_counter.sv
module kwd_down_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enabled,
  input  logic             arm,
  input  logic             service,
  input  logic             tick,
  input  logic [CNT_W-1:0] preload,
  output logic [CNT_W-1:0] count,
  output logic             expired,
  output logic             rst_req,
  output logic             expire_evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic at_end(logic [CNT_W-1:0] c);
    return c <= ONE;
  endfunction

  logic live;
  assign live       = enabled && !expired;
  assign expire_evt = live && tick && !service && at_end(count);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      expired <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      rst_req <= expire_evt;
      if (expire_evt) expired <= 1'b1;
      if (arm)                 count <= preload;
      else if (live && service) count <= preload;
      else if (expire_evt)     count <= '0;
      else if (live && tick)   count <= count - ONE;
    end
  end

  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!enabled && !arm) |=> (count == '0 && !rst_req));
  p_step_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (live && tick && !service && count > ONE) |=> count == $past(count) - ONE);
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (live && service) |=> count == $past(preload));
  p_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
    expire_evt |=> (rst_req && expired && count == '0));
  p_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> (expired && !rst_req && count == '0));
endmodule

// File: rtl/kwd_watchdog.sv
module kwd_watchdog
  import kwd_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] PRELOAD_INIT = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [15:0]      wr_data,
  output logic             rst_req,
  output logic             expired,
  output logic             enabled,
  output logic [CNT_W-1:0] count,
  output logic             key_half
);
  logic [CNT_W-1:0] preload;
  logic arm, key_wr, service, expire_evt;

  kwd_ctrl_regs #(.CNT_W(CNT_W), .PRELOAD_INIT(PRELOAD_INIT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .enabled(enabled), .preload(preload), .arm(arm)
  );

  // Keys only reach the tracker while the watchdog is live.
  assign key_wr = wr_en && (wsel_e'(wr_sel) == SEL_KEY) && enabled && !expired;

  kwd_key_tracker u_keys (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key(wr_data),
    .key_half(key_half), .service(service)
  );

  kwd_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enabled(enabled), .arm(arm),
    .service(service), .tick(tick), .preload(preload), .count(count),
    .expired(expired), .rst_req(rst_req), .expire_evt(expire_evt)
  );

  p_service_needs_half_r6: assert property (@(posedge clk) disable iff (!rst_n)
    service |-> key_half);
  p_race_reload_wins_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (service && tick) |=> (!rst_req && !expired));
  p_disarmed_keys_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !enabled |=> !key_half);
endmodule

// File: tb/kwd_watchdog_test.sv
module kwd_watchdog_test;
  localparam int W = 16;
  localparam logic [15:0] K1 = 16'hE51A;
  localparam logic [15:0] K2 = 16'hA35C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd3;
  logic [15:0] wr_data = '0;
  logic rst_req, expired, enabled, key_half;
  logic [W-1:0] count;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  kwd_watchdog #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rst_req(rst_req), .expired(expired),
    .enabled(enabled), .count(count), .key_half(key_half)
  );

  // Reference model written from the requirements.
  logic [W-1:0] m_cnt, m_pre;
  logic m_en, m_exp, m_rq, m_half;

  function automatic logic [W-1:0] m_after_tick(logic [W-1:0] c);
    return (c > 1) ? c - 1 : '0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = '0; m_pre = '1; m_en = 0; m_exp = 0; m_rq = 0; m_half = 0;
    end else begin
      logic svc, fire, kw;
      svc = 0;
      kw = wr_en && wr_sel == 2'd2 && m_en && !m_exp;
      if (kw) begin
        if (m_half) begin svc = (wr_data == K2); m_half = 0; end
        else m_half = (wr_data == K1);
      end
      fire = m_en && !m_exp && tick && !svc && m_cnt <= 1;
      m_rq = fire;
      if (wr_en && wr_sel == 2'd0 && wr_data[0] && !m_en) begin
        m_en = 1; m_cnt = m_pre;
      end else if (svc) m_cnt = m_pre;
      else if (fire) begin m_cnt = '0; m_exp = 1; end
      else if (m_en && !m_exp && tick) m_cnt = m_after_tick(m_cnt);
      if (wr_en && wr_sel == 2'd1) m_pre = wr_data;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(logic we, logic [1:0] sel, logic [15:0] d, logic tk);
    wr_en = we; wr_sel = sel; wr_data = d; tick = tk;
    @(negedge clk);
    wr_en = 0; wr_sel = 2'd3; wr_data = '0; tick = 0;
  endtask

  task automatic idle(int n, logic tk);
    for (int i = 0; i < n; i++) step(0, 2'd3, '0, tk);
  endtask

  task automatic do_reset();
    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #600000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog timeout actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd517));
    do_reset();
    // R1 reset state
    check("R1 enabled", enabled, 0);
    check("R1 count", count, 0);
    check("R1 rst_req/expired/half", {rst_req, expired, key_half}, 0);
    // R2 disarmed: ticks and keys ignored
    idle(4, 1);
    step(1, 2'd2, K1, 1);
    check("R2 key_half", key_half, 0);
    step(1, 2'd2, K2, 1);
    check("R2 count", count, 0);
    check("R2 rst_req", rst_req, 0);
    // R3 start value then arm
    step(1, 2'd1, 16'd10, 0);
    check("R3 count before arm", count, 0);
    step(1, 2'd0, 16'd1, 0);
    check("R3 enabled", enabled, 1);
    check("R3 count loaded", count, 10);
    // R4 down-count
    idle(3, 1);
    check("R4 count", count, 7);
    // R5 good pair
    step(1, 2'd2, K1, 0);
    check("R5 key_half", key_half, 1);
    step(1, 2'd2, K2, 0);
    check("R5 reload", count, 10);
    // R6 lone second key
    idle(1, 1);
    step(1, 2'd2, K2, 0);
    check("R6 no reload", count, 9);
    // R7 wrong key after first
    step(1, 2'd2, K1, 0);
    step(1, 2'd2, 16'h1234, 0);
    check("R7 half cleared", key_half, 0);
    step(1, 2'd2, K2, 0);
    check("R7 no reload", count, 9);
    step(1, 2'd2, K1, 0);
    step(1, 2'd2, K1, 0);
    check("R7 repeated first clears", key_half, 0);
    // R8 one service per pair
    step(1, 2'd2, K1, 0);
    step(1, 2'd2, K2, 0);
    idle(2, 1);
    step(1, 2'd2, K2, 0);
    check("R8 second K2 ignored", count, 8);
    // R11 disarm attempt
    step(1, 2'd0, 16'd0, 0);
    check("R11 stays enabled", enabled, 1);
    // R13 new start value
    step(1, 2'd1, 16'd5, 0);
    check("R13 count unchanged", count, 8);
    step(1, 2'd2, K1, 0);
    step(1, 2'd2, K2, 0);
    check("R13 new value used", count, 5);
    // R12 reload beats final tick
    idle(4, 1);
    check("R12 count at 1", count, 1);
    step(1, 2'd2, K1, 0);
    step(1, 2'd2, K2, 1);
    check("R12 reload", count, 5);
    check("R12 no expiry", {rst_req, expired}, 0);
    // R9 expiry
    idle(4, 1);
    step(0, 2'd3, '0, 1);
    check("R9 pulse", {rst_req, expired, count}, {1'b1, 1'b1, 16'd0});
    idle(1, 0);
    check("R9 pulse ends", rst_req, 0);
    // R10 after expiry
    step(1, 2'd2, K1, 0);
    step(1, 2'd2, K2, 0);
    idle(5, 1);
    check("R10 no reload", count, 0);
    check("R10 sticky, no re-pulse", {expired, rst_req}, 2'b10);
    do_reset();
    check("R10 cleared by reset", expired, 0);
    // R9 zero start value expires on first tick
    step(1, 2'd1, 16'd0, 0);
    step(1, 2'd0, 16'd1, 0);
    step(0, 2'd3, '0, 1);
    check("R9 zero start", {rst_req, expired}, 2'b11);

    // Random phase against the model
    for (int blk = 0; blk < 8; blk++) begin
      do_reset();
      step(1, 2'd1, 16'(4 + $urandom % 36), 0);
      step(1, 2'd0, 16'd1, 0);
      for (int c = 0; c < 400; c++) begin
        int p;
        logic tk;
        p = $urandom % 16;
        tk = ($urandom % 3) != 0;
        case (p)
          0, 1, 2, 3, 4, 5: step(1, 2'd2, K1, tk);
          6, 7, 8, 9:       step(1, 2'd2, K2, tk);
          10:               step(1, 2'd2, 16'($urandom), tk);
          11:               step(1, 2'd1, 16'(2 + $urandom % 38), tk);
          12:               step(1, 2'd0, 16'($urandom % 2), tk);
          default:          step(0, 2'd3, '0, tk);
        endcase
        check("R4/R5/R9 random state",
              {enabled, expired, rst_req, key_half, count},
              {m_en, m_exp, m_rq, m_half, m_cnt});
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule